// File: doc/BRIEF.md
# Linked-List DMA Descriptor Engine

This block is one DMA channel that walks a chain of descriptors kept in system memory. Software hands it the address of the first descriptor together with a one-cycle start pulse. The engine reads the five-word descriptor into its working registers and then moves the buffer it describes. Each data move is one read beat at the source followed by one write beat at the destination. When the buffer is finished, the engine writes a status word back into the same descriptor. It then follows the descriptor's next pointer, unless the descriptor marks itself as the last one in the chain.

All memory traffic goes over one 32-bit master port with request, grant and ready signals, and only one access is outstanding at a time. The engine reports its progress through three single-cycle events: buffer complete, chain complete and error. It also drives a level that shows whether the channel is enabled.

The control sits in one state machine with the states IDLE, FETCH, READ, WRITE and WBACK. The transitions are:
- IDLE to FETCH on a start pulse.
- FETCH to FETCH for each descriptor word read.
- FETCH to READ after the fifth word, or FETCH to WBACK if the size is zero.
- READ to WRITE.
- WRITE to READ while beats remain, or WRITE to WBACK after the final beat.
- WBACK to FETCH for a chained descriptor, or WBACK to IDLE for the last one.
- Any state back to IDLE on a bus error.

Top module: `lldma_engine`

## Requirements
- R1: After reset the channel is disabled, no bus request is raised and all three event outputs are low.
- R2: A start pulse while the channel is disabled enables it and reads five words, in address order, at pointer+0 (source), +4 (destination), +8 (next pointer), +12 (control A) and +16 (control B). These reads come before any data beat.
- R3: Control A bits [15:0] give the number of data beats. Each beat reads the source address and then writes the returned word to the destination address. A size of zero moves no data.
- R4: Control A bits [25:24] select the beat width: 0 is byte, 1 is halfword, 2 or 3 is word. Each beat advances an address by 1, 2 or 4 bytes. Control B bit 0 holds the source address fixed, and bit 1 holds the destination address fixed.
- R5: After the last beat of a buffer, one word is written to descriptor+12. It is the loaded control A with bits [15:0] equal to the remaining count (zero) and bit 31 (done) set to 1. All other bits are kept.
- R6: evt_buf_done pulses once at the end of every buffer, including buffers in the middle of a chain.
- R7: After a write-back, the next descriptor is fetched from the loaded next pointer straight away. This happens unless both control B bits 4 and 5 are set; one of them alone does not end the chain.
- R8: When a buffer whose control B bits 4 and 5 are both set completes, evt_chain_done pulses together with evt_buf_done and ch_en drops.
- R9: An error response on any fetch, data beat or write-back pulses evt_error, drops ch_en and stops all further bus requests. No write-back is made for that buffer, and no buffer-complete event is raised for it.
- R10: A start pulse while the channel is enabled is ignored, and the pointer given with it is never read.
- R11: A raised bus request keeps its address, direction and data until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that enables the channel |
| desc_ptr | input | 32 | Address of the first descriptor, sampled with start |
| ch_en | output | 1 | Channel enabled |
| evt_buf_done | output | 1 | Buffer complete pulse |
| evt_chain_done | output | 1 | Chain complete pulse |
| evt_error | output | 1 | Bus error pulse |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 for a write access |
| bus_addr | output | 32 | Byte address of the access |
| bus_size | output | 2 | Access width: 0 byte, 1 half, 2 or 3 word |
| bus_wdata | output | 32 | Write data |
| bus_gnt | input | 1 | Request accepted at this edge |
| bus_rdy | input | 1 | Data phase ends at this edge |
| bus_err | input | 1 | Error response, valid with bus_rdy |
| bus_rdata | input | 32 | Read data, valid with bus_rdy |

## Verification
The assertions assume a bus slave that raises bus_rdy for exactly one cycle, only after it has granted an access, and that never grants while no request is up. They also assume that start is a single-cycle pulse. The bench memory model keeps within these rules by construction. It grants only a live request, answers one cycle after the grant, and can withhold the grant on alternate cycles to test R11. The bench drives start only through a task that lowers it on the following cycle.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    localparam int DESC_WORDS = 5;
    localparam int WORD_BYTES = 4;

    // word index inside a descriptor
    localparam int IDX_SRC  = 0;
    localparam int IDX_DST  = 1;
    localparam int IDX_NEXT = 2;
    localparam int IDX_CA   = 3;
    localparam int IDX_CB   = 4;

    // control A fields
    localparam int CA_DONE = 31;
    localparam int CA_WLO  = 24;

    // control B fields
    localparam int CB_SFIX = 0;
    localparam int CB_DFIX = 1;
    localparam int CB_SNOF = 4;
    localparam int CB_DNOF = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_WBACK
    } lldma_state_e;

    typedef enum logic [1:0] {
        BP_IDLE,
        BP_REQ,
        BP_WAIT
    } bp_state_e;

endpackage

// File: rtl/lldma_bus_port.sv
module lldma_bus_port
    import lldma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_start,
    input  logic          acc_we,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic [1:0]    acc_size,
    output logic          acc_done,
    output logic          acc_err,
    output logic [DW-1:0] acc_rdata,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_gnt,
    input  logic          bus_rdy,
    input  logic          bus_err,
    input  logic [DW-1:0] bus_rdata
);

    bp_state_e bp_q, bp_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_q <= BP_IDLE;
        end else begin
            bp_q <= bp_d;
        end
    end

    always_comb begin
        bp_d = bp_q;
        unique case (bp_q)
            BP_IDLE: if (acc_start) bp_d = BP_REQ;
            BP_REQ:  if (bus_gnt)   bp_d = BP_WAIT;
            BP_WAIT: if (bus_rdy)   bp_d = BP_IDLE;
            default: bp_d = BP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_size  <= '0;
            bus_wdata <= '0;
        end else if (bp_q == BP_IDLE && acc_start) begin
            bus_we    <= acc_we;
            bus_addr  <= acc_addr;
            bus_size  <= acc_size;
            bus_wdata <= acc_wdata;
        end
    end

    always_comb begin
        bus_req   = (bp_q == BP_REQ);
        acc_done  = (bp_q == BP_WAIT) && bus_rdy;
        acc_err   = acc_done && bus_err;
        acc_rdata = bus_rdata;
    end

endmodule

// File: rtl/lldma_addr_reg.sv
module lldma_addr_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic          fixed,
    input  logic [1:0]    width,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] step;

    always_comb begin
        if (fixed) begin
            step = '0;
        end else begin
            unique case (width)
                2'd0:    step = AW'(1);
                2'd1:    step = AW'(2);
                default: step = AW'(4);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (adv) begin
            addr <= addr + step;
        end
    end

endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
    import lldma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] desc_ptr,
    output logic          ch_en,
    output logic          evt_buf_done,
    output logic          evt_chain_done,
    output logic          evt_error,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_gnt,
    input  logic          bus_rdy,
    input  logic          bus_err,
    input  logic [DW-1:0] bus_rdata
);

    localparam int IDX_W   = $clog2(DESC_WORDS);
    localparam int OFS_SH  = $clog2(WORD_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);
    localparam logic [AW-1:0]    CA_OFS   = AW'(IDX_CA * WORD_BYTES);

    lldma_state_e  st_q, st_d;
    logic [IDX_W-1:0] widx;
    logic [AW-1:0] cur_desc;
    logic [AW-1:0] next_ptr;
    logic [DW-1:0] ctrl_a;
    logic          cb_sfix, cb_dfix, cb_snof, cb_dnof;
    logic [CNT_W-1:0] remain;
    logic [DW-1:0] data_q;
    logic          pend;

    logic          acc_start, acc_we, acc_done, acc_err;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata, acc_rdata;
    logic [1:0]    acc_size;

    logic          ok, fetch_ok, read_ok, write_ok, wback_ok;
    logic          is_last, size_zero;
    logic [1:0]    beat_w;
    logic [AW-1:0] ptr_addr [2];
    logic [DW-1:0] wb_word;

    assign ok        = acc_done && !acc_err;
    assign fetch_ok  = ok && (st_q == ST_FETCH);
    assign read_ok   = ok && (st_q == ST_READ);
    assign write_ok  = ok && (st_q == ST_WRITE);
    assign wback_ok  = ok && (st_q == ST_WBACK);
    assign is_last   = cb_snof && cb_dnof;
    assign size_zero = (ctrl_a[CNT_W-1:0] == '0);
    assign beat_w    = ctrl_a[CA_WLO+1:CA_WLO];
    assign wb_word   = {1'b1, ctrl_a[DW-2:CNT_W], remain};

    // source (0) and destination (1) address registers
    for (genvar g = 0; g < 2; g++) begin : g_ptr
        lldma_addr_reg #(.AW(AW)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (fetch_ok && (widx == IDX_W'(g))),
            .load_val (acc_rdata[AW-1:0]),
            .adv      ((g == 0) ? read_ok : write_ok),
            .fixed    ((g == 0) ? cb_sfix : cb_dfix),
            .width    (beat_w),
            .addr     (ptr_addr[g])
        );
    end

    lldma_bus_port #(.AW(AW), .DW(DW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_start (acc_start),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_size  (acc_size),
        .acc_done  (acc_done),
        .acc_err   (acc_err),
        .acc_rdata (acc_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_gnt   (bus_gnt),
        .bus_rdy   (bus_rdy),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) st_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (acc_done) begin
                    if (acc_err)              st_d = ST_IDLE;
                    else if (widx == IDX_LAST) st_d = size_zero ? ST_WBACK : ST_READ;
                end
            end
            ST_READ: begin
                if (acc_done) st_d = acc_err ? ST_IDLE : ST_WRITE;
            end
            ST_WRITE: begin
                if (acc_done) begin
                    if (acc_err)                      st_d = ST_IDLE;
                    else if (remain == CNT_W'(1))     st_d = ST_WBACK;
                    else                              st_d = ST_READ;
                end
            end
            ST_WBACK: begin
                if (acc_done) begin
                    if (acc_err || is_last) st_d = ST_IDLE;
                    else                    st_d = ST_FETCH;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // access request outputs toward the bus port
    always_comb begin
        acc_start = (st_q != ST_IDLE) && !pend;
        acc_we    = 1'b0;
        acc_addr  = cur_desc;
        acc_wdata = data_q;
        acc_size  = 2'd2;
        unique case (st_q)
            ST_FETCH: acc_addr = cur_desc + {{(AW-IDX_W-OFS_SH){1'b0}}, widx, {OFS_SH{1'b0}}};
            ST_READ: begin
                acc_addr = ptr_addr[0];
                acc_size = beat_w;
            end
            ST_WRITE: begin
                acc_we   = 1'b1;
                acc_addr = ptr_addr[1];
                acc_size = beat_w;
            end
            ST_WBACK: begin
                acc_we    = 1'b1;
                acc_addr  = cur_desc + CA_OFS;
                acc_wdata = wb_word;
            end
            default: acc_start = 1'b0;
        endcase
    end

    // working registers and events
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx           <= '0;
            cur_desc       <= '0;
            next_ptr       <= '0;
            ctrl_a         <= '0;
            cb_sfix        <= 1'b0;
            cb_dfix        <= 1'b0;
            cb_snof        <= 1'b0;
            cb_dnof        <= 1'b0;
            remain         <= '0;
            data_q         <= '0;
            pend           <= 1'b0;
            ch_en          <= 1'b0;
            evt_buf_done   <= 1'b0;
            evt_chain_done <= 1'b0;
            evt_error      <= 1'b0;
        end else begin
            evt_buf_done   <= 1'b0;
            evt_chain_done <= 1'b0;
            evt_error      <= 1'b0;

            if (acc_start)     pend <= 1'b1;
            else if (acc_done) pend <= 1'b0;

            if (st_q == ST_IDLE && start) begin
                cur_desc <= desc_ptr;
                widx     <= '0;
                ch_en    <= 1'b1;
            end

            if (fetch_ok) begin
                unique case (widx)
                    IDX_W'(IDX_NEXT): next_ptr <= acc_rdata[AW-1:0];
                    IDX_W'(IDX_CA): begin
                        ctrl_a          <= acc_rdata;
                        ctrl_a[CA_DONE] <= 1'b0;
                    end
                    IDX_W'(IDX_CB): begin
                        cb_sfix <= acc_rdata[CB_SFIX];
                        cb_dfix <= acc_rdata[CB_DFIX];
                        cb_snof <= acc_rdata[CB_SNOF];
                        cb_dnof <= acc_rdata[CB_DNOF];
                        remain  <= ctrl_a[CNT_W-1:0];
                    end
                    default: ;
                endcase
                widx <= widx + IDX_W'(1);
            end

            if (read_ok)  data_q <= acc_rdata;
            if (write_ok) remain <= remain - CNT_W'(1);

            if (wback_ok) begin
                evt_buf_done <= 1'b1;
                if (is_last) begin
                    evt_chain_done <= 1'b1;
                    ch_en          <= 1'b0;
                end else begin
                    cur_desc <= next_ptr;
                    widx     <= '0;
                end
            end

            if (acc_err) begin
                evt_error <= 1'b1;
                ch_en     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lldma_engine_chk.sv
module lldma_engine_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          ch_en,
    input logic          evt_buf_done,
    input logic          evt_chain_done,
    input logic          evt_error,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_gnt
);

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |-> !bus_req);

    a_r2_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
        start && !ch_en |=> ch_en);

    a_r6_chain_has_buf: assert property (@(posedge clk) disable iff (!rst_n)
        evt_chain_done |-> evt_buf_done);

    a_r8_chain_end_off: assert property (@(posedge clk) disable iff (!rst_n)
        evt_chain_done |-> !ch_en);

    a_r9_error_off: assert property (@(posedge clk) disable iff (!rst_n)
        evt_error |-> !ch_en && !evt_buf_done);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_wdata));

endmodule

bind lldma_engine lldma_engine_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .ch_en          (ch_en),
    .evt_buf_done   (evt_buf_done),
    .evt_chain_done (evt_chain_done),
    .evt_error      (evt_error),
    .bus_req        (bus_req),
    .bus_we         (bus_we),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_gnt        (bus_gnt)
);

// File: tb/lldma_engine_bench.sv
`timescale 1ns/1ps
module lldma_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] desc_ptr = '0;
    logic        ch_en, evt_buf_done, evt_chain_done, evt_error;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic        bus_gnt = 1'b0, bus_rdy = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #2 clk = ~clk;

    lldma_engine u_lldma_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_ptr(desc_ptr),
        .ch_en(ch_en), .evt_buf_done(evt_buf_done),
        .evt_chain_done(evt_chain_done), .evt_error(evt_error),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
        .bus_rdy(bus_rdy), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    // memory model and observation
    logic [31:0] mem [0:1023];
    logic        stall_mode = 1'b0, stall_tog = 1'b0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic        rp = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0, p_wdata = '0;
    logic [31:0] log_addr [0:127];
    logic        log_we [0:127];
    int          log_n = 0, wr_n = 0, n_buf = 0, n_chain = 0, n_err = 0;
    logic [31:0] last_rd = '0, last_wr = '0;
    int          checks = 0, fails = 0;

    always @(negedge clk) begin
        if (rp) begin
            bus_rdy   = 1'b1;
            bus_err   = (p_addr == err_addr);
            bus_rdata = mem[p_addr[11:2]];
            if (p_we && !bus_err) mem[p_addr[11:2]] = p_wdata;
            rp = 1'b0;
        end else begin
            bus_rdy = 1'b0;
            bus_err = 1'b0;
        end
        bus_gnt   = bus_req && !(stall_mode && stall_tog);
        stall_tog = ~stall_tog;
        if (bus_req && bus_gnt) begin
            rp = 1'b1; p_addr = bus_addr; p_we = bus_we; p_wdata = bus_wdata;
            if (log_n < 128) begin
                log_addr[log_n] = bus_addr;
                log_we[log_n]   = bus_we;
            end
            log_n++;
            if (bus_we && bus_addr >= 32'h800 && bus_addr < 32'hC00) begin
                wr_n++; last_wr = bus_addr;
            end
            if (!bus_we && bus_addr >= 32'h400 && bus_addr < 32'h800) last_rd = bus_addr;
        end
        if (evt_buf_done)   n_buf++;
        if (evt_chain_done) n_chain++;
        if (evt_error)      n_err++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic arm();
        log_n = 0; wr_n = 0; n_buf = 0; n_chain = 0; n_err = 0;
        last_rd = '0; last_wr = '0;
    endtask

    task automatic pulse_start(input logic [31:0] ptr);
        @(negedge clk); start = 1'b1; desc_ptr = ptr;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (ch_en === 1'b1 && t < 4000) begin
            @(negedge clk); t++;
        end
        check(t < 4000, "R8", "channel never went idle", 32'(t), 32'd0);
        repeat (3) @(negedge clk);
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] n, input logic [31:0] ca, input logic [31:0] cb);
        mem[a[11:2]]     = s;
        mem[a[11:2] + 1] = d;
        mem[a[11:2] + 2] = n;
        mem[a[11:2] + 3] = ca;
        mem[a[11:2] + 4] = cb;
    endtask

    task automatic fill_data();
        for (int k = 0; k < 64; k++) begin
            mem[10'h100 + k] = 32'hA000_0000 + 32'(k);
            mem[10'h200 + k] = 32'h0;
        end
    endtask

    // vector fields: width[27:26] src_fixed[25] dst_fixed[24] count[23:16]
    //                expected last src offset[15:8] expected last dst offset[7:0]
    localparam logic [27:0] VECS [6] = '{
        {2'd2, 1'b0, 1'b0, 8'd4, 8'd12, 8'd12},
        {2'd0, 1'b0, 1'b0, 8'd3, 8'd2,  8'd2 },
        {2'd1, 1'b0, 1'b1, 8'd5, 8'd8,  8'd0 },
        {2'd2, 1'b1, 1'b0, 8'd2, 8'd0,  8'd4 },
        {2'd3, 1'b0, 1'b0, 8'd2, 8'd4,  8'd4 },
        {2'd2, 1'b0, 1'b0, 8'd1, 8'd0,  8'd0 }
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] ca, exp_wb;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(ch_en == 1'b0, "R1", "ch_en after reset", 32'(ch_en), 32'd0);
        check(bus_req == 1'b0, "R1", "bus_req after reset", 32'(bus_req), 32'd0);
        check({evt_buf_done, evt_chain_done, evt_error} == 3'b0, "R1", "events after reset",
              32'({evt_buf_done, evt_chain_done, evt_error}), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // vector table: one last-marked descriptor per row
        for (int i = 0; i < 6; i++) begin
            logic [1:0] w;
            logic sf, df;
            logic [7:0] cnt, es, ed;
            {w, sf, df, cnt, es, ed} = VECS[i];
            fill_data();
            ca = {1'b0, 5'b0, w, 8'h5A, 8'h00, cnt};
            put_desc(32'h100, 32'h400, 32'h800, 32'h0, ca, {26'b0, 2'b11, 2'b00, df, sf});
            arm();
            pulse_start(32'h100);
            wait_idle();
            if (i == 0) begin
                for (int k = 0; k < 5; k++)
                    check(log_addr[k] == 32'h100 + 32'(4 * k) && !log_we[k], "R2",
                          "descriptor fetch order", log_addr[k], 32'h100 + 32'(4 * k));
                check(log_addr[5] == 32'h400, "R2", "first data read after fetch",
                      log_addr[5], 32'h400);
            end
            check(wr_n == 32'(cnt), "R3", "data beat count", 32'(wr_n), 32'(cnt));
            check(last_rd == 32'h400 + 32'(es), "R4", "last source address",
                  last_rd, 32'h400 + 32'(es));
            check(last_wr == 32'h800 + 32'(ed), "R4", "last destination address",
                  last_wr, 32'h800 + 32'(ed));
            exp_wb = {1'b1, 5'b0, w, 8'h5A, 16'h0};
            check(mem[10'h43] == exp_wb, "R5", "write-back word", mem[10'h43], exp_wb);
            check(n_buf == 1, "R6", "buffer events", 32'(n_buf), 32'd1);
            check(n_chain == 1 && ch_en == 1'b0, "R8", "chain end", 32'(n_chain), 32'd1);
            if (w >= 2'd2 && !df) begin
                for (int k = 0; k < 32'(cnt); k++)
                    check(mem[10'h200 + k] == 32'hA000_0000 + (sf ? 32'd0 : 32'(k)), "R3",
                          "copied word", mem[10'h200 + k],
                          32'hA000_0000 + (sf ? 32'd0 : 32'(k)));
            end
        end

        // chain of three with grant stalls; middle descriptors set one stop bit only
        fill_data();
        stall_mode = 1'b1;
        put_desc(32'h100, 32'h400, 32'h800, 32'h140, 32'h0200_0002, 32'h10);
        put_desc(32'h140, 32'h410, 32'h810, 32'h180, 32'h0200_0002, 32'h20);
        put_desc(32'h180, 32'h420, 32'h820, 32'h0,   32'h0200_0002, 32'h30);
        arm();
        pulse_start(32'h100);
        wait_idle();
        stall_mode = 1'b0;
        check(n_buf == 3, "R6", "buffer events in chain", 32'(n_buf), 32'd3);
        check(n_chain == 1, "R8", "chain events in chain", 32'(n_chain), 32'd1);
        check(log_n == 30, "R7", "accesses for three descriptors", 32'(log_n), 32'd30);
        check(log_addr[10] == 32'h140 && log_addr[20] == 32'h180, "R7", "next pointer followed",
              log_addr[20], 32'h180);
        check(mem[10'h53] == 32'h8200_0000, "R5", "middle write-back", mem[10'h53], 32'h8200_0000);
        check(mem[10'h209] == 32'hA000_0009, "R11", "data under grant stalls",
              mem[10'h209], 32'hA000_0009);

        // zero size buffer
        put_desc(32'h100, 32'h400, 32'h800, 32'h0, 32'h0233_0000, 32'h30);
        arm();
        pulse_start(32'h100);
        wait_idle();
        check(wr_n == 0 && log_n == 6, "R3", "zero size accesses", 32'(log_n), 32'd6);
        check(mem[10'h43] == 32'h8233_0000, "R5", "zero size write-back", mem[10'h43], 32'h8233_0000);
        check(n_buf == 1, "R6", "zero size buffer event", 32'(n_buf), 32'd1);

        // error on the second data read
        ca = 32'h0200_0004;
        put_desc(32'h100, 32'h400, 32'h800, 32'h0, ca, 32'h30);
        err_addr = 32'h404;
        arm();
        pulse_start(32'h100);
        wait_idle();
        repeat (20) @(negedge clk);
        check(n_err == 1 && ch_en == 1'b0, "R9", "data error event", 32'(n_err), 32'd1);
        check(n_buf == 0 && n_chain == 0, "R9", "no completion after error", 32'(n_buf), 32'd0);
        check(wr_n == 1 && log_n == 8, "R9", "accesses stop after error", 32'(log_n), 32'd8);
        check(mem[10'h43] == ca, "R9", "no write-back after error", mem[10'h43], ca);

        // error on the next-pointer fetch
        err_addr = 32'h108;
        arm();
        pulse_start(32'h100);
        wait_idle();
        check(n_err == 1 && log_n == 3 && wr_n == 0, "R9", "fetch error stops walk",
              32'(log_n), 32'd3);
        err_addr = 32'hFFFF_FFFF;

        // start while busy
        stall_mode = 1'b1;
        put_desc(32'h100, 32'h400, 32'h800, 32'h0, 32'h0200_0008, 32'h30);
        put_desc(32'h200, 32'h400, 32'h900, 32'h0, 32'h0200_0001, 32'h30);
        arm();
        pulse_start(32'h100);
        repeat (3) @(negedge clk);
        pulse_start(32'h200);
        wait_idle();
        stall_mode = 1'b0;
        begin
            int hits = 0;
            for (int k = 0; k < 128; k++)
                if (k < log_n && log_addr[k] >= 32'h200 && log_addr[k] < 32'h214) hits++;
            check(hits == 0, "R10", "ignored pointer read", 32'(hits), 32'd0);
        end
        check(n_buf == 1 && log_n == 22, "R10", "busy start had no effect", 32'(log_n), 32'd22);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule